// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block holds the programming state of an interrupt router and is reached through two bus locations. Software first writes a register index into a select location, then reads or writes a data window; the window acts on whichever register the select location names. Behind the window are:

- an identity register holding a 4-bit router number;
- a constant revision word that also reports how many inputs the router has;
- an arbitration word that mirrors the identity;
- a routing table with one configuration word and one destination word for each interrupt input (24 inputs by default).

The routing table is exported in parallel to a downstream delivery engine, which is outside this block. Each write to a configuration word also sends the engine a one-cycle notice carrying the entry number, so the engine can re-evaluate that input.

Configuration words hold fields that are owned by hardware, such as delivery status and remote acknowledge. A software write merges with the stored word through a fixed read-only mask, so those fields keep their value. Reads are registered and come back one cycle after the request, marked by a valid flag. A location that decodes to nothing reads as zero, and a write to it is dropped.

Top module: `irq_route_regfile`

## Requirements
- R1: After reset, every configuration word reads 0x00010000 (only the mask bit, bit 16, set). Every destination word, the identity and the select register read zero, and neither `rdValid` nor `cfgWrStb` is asserted.
- R2: A 32-bit write at bus offset 0x00 loads the select register. A 32-bit read at offset 0x00 returns the last value written there.
- R3: A read request in one cycle gives `rdValid` high with the data in the next cycle only. `rdValid` is low in every cycle that does not follow a request.
- R4: Writing index 0 stores bits 27:24 of the written word as the identity. Index 0 and index 2 both read the identity in bits 27:24, with all other bits zero. Writes to any other index leave the identity unchanged.
- R5: Index 1 reads 0x00170011: 0x11 in bits 7:0 and (entry count − 1) in bits 23:16. Writes to index 1 and index 2 change nothing.
- R6: Index 0x10+2·e selects the configuration word of entry e, and index 0x11+2·e selects its destination word, for e from 0 to 23. A destination write keeps only bits 31:24; the other bits read as zero.
- R7: A configuration write stores (written & ~M) | (old & M), where M = 0xFFFE5000 covers bit 12, bit 14 and bits 31:17. From the bus, writing 0xFFFFFFFF to a word whose read-only bits are zero reads back 0x0001AFFF. The read-only bits never change.
- R8: A configuration write raises `cfgWrStb` for exactly the next cycle, with `cfgWrIdx` equal to the entry number. Writes to destination words, to the identity, to the select register or to unmapped places never raise it.
- R9: A byte read at offset 0x10+k (k = 0..3) returns bits 8k+7:8k of the selected register in bits 7:0, with the upper bits zero. Byte writes at any offset change nothing.
- R10: 32-bit reads at offsets other than 0x00 and 0x10, byte reads outside 0x10–0x13, and window reads of indices 3–0x0F or 0x40 and above all return zero. Window writes to those indices change nothing.
- R11: `cfgTable[32e+31:32e]` always equals configuration word e, and `dstTable[8e+7:8e]` always equals bits 31:24 of destination word e. Both are updated in the same cycle that `cfgWrStb` would report the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write request this cycle |
| busRd | input | 1 | Read request this cycle |
| busByte | input | 1 | 1 = byte access, 0 = 32-bit access |
| busAddr | input | 5 | Byte offset within the two-location window |
| busWData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid when `rdValid` is high |
| rdValid | output | 1 | Read data valid, one cycle after `busRd` |
| cfgTable | output | 768 | All configuration words, entry e at bits 32e+31:32e |
| dstTable | output | 192 | All destination bytes, entry e at bits 8e+7:8e |
| cfgWrStb | output | 1 | One-cycle notice of a configuration write |
| cfgWrIdx | output | 5 | Entry number that goes with `cfgWrStb` |

## Verification
The hardest state to reach from the ports is a particular table word together with its read-back path. Every such access takes two steps, and the result depends on both a select value written earlier and the offset and width used now. The stimulus therefore mixes random select writes with random window accesses. Select values are drawn from a range that straddles the table on both sides, so that the holes at 3–0x0F and 0x40 and above are hit. Random byte lanes and stray offsets are added, and directed cases cover all-ones configuration writes and writes to the constant registers.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DATA_W      = 32;
  localparam int IDX_FIELD_W = 8;
  localparam logic [DATA_W-1:0] CFG_RO_MASK = 32'hFFFE_5000;
  localparam logic [DATA_W-1:0] CFG_RESET   = 32'h0001_0000;

  typedef enum logic [2:0] {
    REG_NONE, REG_ID, REG_VER, REG_ARB, REG_CFG, REG_DST
  } regKind_e;

  typedef enum logic [1:0] {
    SRC_ZERO, SRC_SEL, SRC_REG
  } rdSrc_e;

  typedef struct packed {
    logic                   idWr;
    logic                   cfgWr;
    logic                   dstWr;
    logic [IDX_FIELD_W-1:0] entry;
    regKind_e               kind;
    logic                   rdEn;
    rdSrc_e                 rdSrc;
    logic                   byteMode;
    logic [1:0]             byteLane;
  } ctrlStb_t;
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int ADDR_W      = 5,
  parameter int SEL_OFFS    = 0,
  parameter int WIN_OFFS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busByte,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] selReg,
  output ctrlStb_t          stb
);
  localparam logic [DATA_W-1:0] TABLE_BASE = 32'h10;
  localparam logic [DATA_W-1:0] TABLE_END  = TABLE_BASE + DATA_W'(2 * NUM_ENTRIES);
  localparam logic [ADDR_W-1:0] SEL_A      = ADDR_W'(SEL_OFFS);
  localparam logic [ADDR_W-1:0] WIN_A      = ADDR_W'(WIN_OFFS);
  localparam logic [ADDR_W-1:0] WIN_LAST_A = ADDR_W'(WIN_OFFS + 3);

  logic hitSel, hitWin, hitByteWin, wordWrWin;
  logic [IDX_FIELD_W:0] tblOffs;
  regKind_e kind;
  logic [ADDR_W-1:0] laneOffs;

  assign hitSel     = (busAddr == SEL_A);
  assign hitWin     = (busAddr == WIN_A);
  assign hitByteWin = (busAddr >= WIN_A) && (busAddr <= WIN_LAST_A);
  assign wordWrWin  = busWr && !busByte && hitWin;
  assign tblOffs    = (IDX_FIELD_W+1)'(selReg - TABLE_BASE);
  assign laneOffs   = busAddr - WIN_A;

  always_comb begin
    kind = REG_NONE;
    if (selReg == 32'd0)      kind = REG_ID;
    else if (selReg == 32'd1) kind = REG_VER;
    else if (selReg == 32'd2) kind = REG_ARB;
    else if (selReg >= TABLE_BASE && selReg < TABLE_END)
      kind = tblOffs[0] ? REG_DST : REG_CFG;
  end

  always_comb begin
    stb          = '0;
    stb.kind     = kind;
    stb.entry    = tblOffs[IDX_FIELD_W:1];
    stb.idWr     = wordWrWin && (kind == REG_ID);
    stb.cfgWr    = wordWrWin && (kind == REG_CFG);
    stb.dstWr    = wordWrWin && (kind == REG_DST);
    stb.rdEn     = busRd;
    stb.byteMode = busByte;
    stb.byteLane = laneOffs[1:0];
    if (!busByte) begin
      if (hitSel)      stb.rdSrc = SRC_SEL;
      else if (hitWin) stb.rdSrc = SRC_REG;
      else             stb.rdSrc = SRC_ZERO;
    end else begin
      stb.rdSrc = hitByteWin ? SRC_REG : SRC_ZERO;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          selReg <= '0;
    else if (busWr && !busByte && hitSel) selReg <= busWData;
  end

  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busByte && hitSel) |=> (selReg == $past(busWData)));

  // R9
  byte_wr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busByte) |-> !(stb.idWr || stb.cfgWr || stb.dstWr));

  // R8
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.idWr, stb.cfgWr, stb.dstWr}));
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int          NUM_ENTRIES  = 24,
  parameter int          IDX_W        = 5,
  parameter int          ID_W         = 4,
  parameter int          ID_LSB       = 24,
  parameter int          DST_W        = 8,
  parameter logic [7:0]  VERSION_CODE = 8'h11
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStb_t                      stb,
  input  logic [DATA_W-1:0]             busWData,
  input  logic [DATA_W-1:0]             selReg,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdValid,
  output logic [NUM_ENTRIES*DATA_W-1:0] cfgFlat,
  output logic [NUM_ENTRIES*DST_W-1:0]  dstFlat,
  output logic                          cfgWrStb,
  output logic [IDX_W-1:0]              cfgWrIdx
);
  localparam int DST_LSB = DATA_W - DST_W;

  logic [ID_W-1:0]   idReg;
  logic [DATA_W-1:0] cfgMem [NUM_ENTRIES];
  logic [DST_W-1:0]  dstMem [NUM_ENTRIES];
  logic [DATA_W-1:0] cfgSel, regWord, rdWord;
  logic [DST_W-1:0]  dstSel;

  always_ff @(posedge clk) begin
    if (!rstN)          idReg <= '0;
    else if (stb.idWr)  idReg <= busWData[ID_LSB +: ID_W];
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgMem[e] <= CFG_RESET;
        dstMem[e] <= '0;
      end else begin
        if (stb.cfgWr && stb.entry == IDX_FIELD_W'(e))
          cfgMem[e] <= (busWData & ~CFG_RO_MASK) | (cfgMem[e] & CFG_RO_MASK);
        if (stb.dstWr && stb.entry == IDX_FIELD_W'(e))
          dstMem[e] <= busWData[DST_LSB +: DST_W];
      end
    end
    assign cfgFlat[e*DATA_W +: DATA_W] = cfgMem[e];
    assign dstFlat[e*DST_W +: DST_W]   = dstMem[e];

    // R7
    ro_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
      $stable(cfgMem[e] & CFG_RO_MASK));
  end

  always_comb begin
    cfgSel = '0;
    dstSel = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (stb.entry == IDX_FIELD_W'(e)) begin
        cfgSel = cfgMem[e];
        dstSel = dstMem[e];
      end
    end
  end

  always_comb begin
    regWord = '0;
    unique case (stb.kind)
      REG_ID, REG_ARB: regWord[ID_LSB +: ID_W] = idReg;
      REG_VER: begin
        regWord[7:0]   = VERSION_CODE;
        regWord[23:16] = 8'(NUM_ENTRIES - 1);
      end
      REG_CFG: regWord = cfgSel;
      REG_DST: regWord[DST_LSB +: DST_W] = dstSel;
      default: regWord = '0;
    endcase
  end

  always_comb begin
    unique case (stb.rdSrc)
      SRC_SEL: rdWord = selReg;
      SRC_REG: rdWord = stb.byteMode
                        ? ((regWord >> {stb.byteLane, 3'b000}) & 32'hFF)
                        : regWord;
      default: rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData   <= '0;
      rdValid  <= 1'b0;
      cfgWrStb <= 1'b0;
      cfgWrIdx <= '0;
    end else begin
      rdValid  <= stb.rdEn;
      if (stb.rdEn) rdData <= rdWord;
      cfgWrStb <= stb.cfgWr;
      cfgWrIdx <= stb.entry[IDX_W-1:0];
    end
  end

  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn |=> rdValid);

  // R3
  rd_no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(stb.rdEn));

  // R8
  dst_no_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dstWr || stb.idWr) |=> !cfgWrStb);

  // R4
  id_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.idWr |=> $stable(idReg));
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irq_route_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int ADDR_W      = 5,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int DST_W      = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWr,
  input  logic                          busRd,
  input  logic                          busByte,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWData,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdValid,
  output logic [NUM_ENTRIES*DATA_W-1:0] cfgTable,
  output logic [NUM_ENTRIES*DST_W-1:0]  dstTable,
  output logic                          cfgWrStb,
  output logic [IDX_W-1:0]              cfgWrIdx
);
  ctrlStb_t          stb;
  logic [DATA_W-1:0] selReg;

  irq_route_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busByte(busByte),
    .busAddr(busAddr), .busWData(busWData), .selReg(selReg), .stb(stb)
  );

  irq_route_dp #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .DST_W(DST_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busWData(busWData), .selReg(selReg),
    .rdData(rdData), .rdValid(rdValid), .cfgFlat(cfgTable), .dstFlat(dstTable),
    .cfgWrStb(cfgWrStb), .cfgWrIdx(cfgWrIdx)
  );
endmodule

// File: tb/irq_route_regfile_tb.sv
module irq_route_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 24;
  localparam logic [31:0] WR_KEEP = 32'h0001_AFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 0, busRd = 0, busByte = 0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] rdData;
  logic rdValid, cfgWrStb;
  logic [N*32-1:0] cfgTable;
  logic [N*8-1:0]  dstTable;
  logic [4:0] cfgWrIdx;

  irq_route_regfile dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busByte(busByte),
    .busAddr(busAddr), .busWData(busWData), .rdData(rdData), .rdValid(rdValid),
    .cfgTable(cfgTable), .dstTable(dstTable), .cfgWrStb(cfgWrStb), .cfgWrIdx(cfgWrIdx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nTests = 0, nFail = 0;
  logic [31:0] selM;
  logic [3:0]  idM;
  logic [31:0] cfgM [N];
  logic [7:0]  dstM [N];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] regVal(input logic [31:0] idx);
    int e;
    if (idx == 0 || idx == 2) return {4'b0, idM, 24'b0};
    if (idx == 1) return 32'h0017_0011;
    if (idx >= 32'h10 && idx < 32'h10 + 2*N) begin
      e = int'((idx - 32'h10) >> 1);
      return idx[0] ? {dstM[e], 24'b0} : cfgM[e];
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] expRead(input logic [4:0] a, input bit b);
    if (!b) begin
      if (a == 5'h00) return selM;
      if (a == 5'h10) return regVal(selM);
      return 32'h0;
    end
    if (a >= 5'h10 && a <= 5'h13) return (regVal(selM) >> (8 * (a - 5'h10))) & 32'hFF;
    return 32'h0;
  endfunction

  task automatic busWrite(input logic [4:0] a, input bit b, input logic [31:0] d);
    bit expStb;
    int e;
    expStb = 0;
    e = 0;
    @(negedge clk);
    busWr = 1; busByte = b; busAddr = a; busWData = d;
    @(negedge clk);
    busWr = 0; busByte = 0;
    if (!b && a == 5'h00) selM = d;
    else if (!b && a == 5'h10) begin
      if (selM == 0) idM = d[27:24];
      else if (selM >= 32'h10 && selM < 32'h10 + 2*N) begin
        e = int'((selM - 32'h10) >> 1);
        if (selM[0]) dstM[e] = d[31:24];
        else begin
          cfgM[e] = (d & WR_KEEP) | (cfgM[e] & ~WR_KEEP);
          expStb = 1;
        end
      end
    end
    check(cfgWrStb == expStb, "R8 strobe", {31'b0, cfgWrStb}, {31'b0, expStb});
    if (expStb) begin
      check(cfgWrIdx == 5'(e), "R8 index", {27'b0, cfgWrIdx}, e);
      check(cfgTable[e*32 +: 32] == cfgM[e], "R11 cfg export", cfgTable[e*32 +: 32], cfgM[e]);
    end
  endtask

  task automatic busRead(input logic [4:0] a, input bit b, input string tag);
    logic [31:0] exp;
    exp = expRead(a, b);
    @(negedge clk);
    busRd = 1; busByte = b; busAddr = a;
    @(negedge clk);
    busRd = 0; busByte = 0;
    check(rdValid == 1'b1, "R3 valid", {31'b0, rdValid}, 32'h1);
    check(rdData == exp, tag, rdData, exp);
  endtask

  task automatic selRead(input logic [31:0] idx, input string tag);
    busWrite(5'h00, 0, idx);
    busRead(5'h10, 0, tag);
  endtask

  bit done = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    selM = 0; idM = 0;
    for (int e = 0; e < N; e++) begin cfgM[e] = 32'h0001_0000; dstM[e] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check(rdValid == 0, "R1 rdValid", {31'b0, rdValid}, 0);
    check(cfgWrStb == 0, "R1 cfgWrStb", {31'b0, cfgWrStb}, 0);
    for (int e = 0; e < N; e++) begin
      check(cfgTable[e*32 +: 32] == 32'h0001_0000, "R1 cfg reset", cfgTable[e*32 +: 32], 32'h0001_0000);
      check(dstTable[e*8 +: 8] == 0, "R1 dst reset", {24'b0, dstTable[e*8 +: 8]}, 0);
    end
    busRead(5'h00, 0, "R1 select reset");
    selRead(32'h10, "R1 cfg0 via window");
    selRead(32'h3F, "R1 dst23 via window");

    // R3 valid drops after the single cycle
    @(negedge clk);
    check(rdValid == 0, "R3 valid drop", {31'b0, rdValid}, 0);

    // R2 select read-back
    busWrite(5'h00, 0, 32'hDEAD_BEEF);
    busRead(5'h00, 0, "R2 select readback");

    // R4 identity
    busWrite(5'h00, 0, 32'h0);
    busWrite(5'h10, 0, 32'hFFFF_FFFF);
    busRead(5'h10, 0, "R4 id read idx0");
    selRead(32'h2, "R4 id read idx2");

    // R5 version, writes to 1 and 2 ignored
    selRead(32'h1, "R5 version");
    busWrite(5'h10, 0, 32'h0);
    busRead(5'h10, 0, "R5 version after write");
    selRead(32'h2, "R5 arb before write");
    busWrite(5'h10, 0, 32'h0);
    selRead(32'h0, "R5 id kept after arb write");

    // R7 all-ones config write, R6 mapping to last entry
    selRead(32'h3E, "R6 cfg23 reset");
    busWrite(5'h10, 0, 32'hFFFF_FFFF);
    busRead(5'h10, 0, "R7 merge all-ones");
    busWrite(5'h10, 0, 32'h0);
    busRead(5'h10, 0, "R7 merge zero");
    busWrite(5'h00, 0, 32'h3F);
    busWrite(5'h10, 0, 32'hA5FF_FFFF);
    busRead(5'h10, 0, "R6 dst keeps top byte");

    // R9 byte lanes and byte write ignored
    busWrite(5'h00, 0, 32'h1);
    for (int k = 0; k < 4; k++) busRead(5'(16 + k), 1, "R9 byte lane");
    busWrite(5'h00, 0, 32'h3F);
    busWrite(5'h10, 1, 32'h1111_1111);
    busRead(5'h10, 0, "R9 byte write ignored");
    busWrite(5'h00, 1, 32'h0);
    busRead(5'h00, 0, "R9 byte select write ignored");

    // R10 unmapped
    busRead(5'h04, 0, "R10 stray word offset");
    busRead(5'h11, 0, "R10 word at 0x11");
    busRead(5'h00, 1, "R10 byte at 0x00");
    selRead(32'h0F, "R10 index 0x0F");
    busWrite(5'h10, 0, 32'hFFFF_FFFF);
    selRead(32'h40, "R10 index 0x40");
    busWrite(5'h10, 0, 32'hFFFF_FFFF);
    busRead(5'h10, 0, "R10 index 0x40 after write");
    busWrite(5'h05, 0, 32'hFFFF_FFFF);
    busRead(5'h00, 0, "R10 stray write");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0, 1: busWrite(5'h00, 0, $urandom % 32'h48);
        2: busWrite(5'h10, 0, $urandom);
        3: busRead(5'h10, 0, "R6 random window read");
        4: busRead(5'(16 + ($urandom % 4)), 1, "R9 random byte read");
        default: begin
          if ($urandom % 2) busRead(5'($urandom), $urandom % 2, "R10 random offset read");
          else busWrite(5'(16 + ($urandom % 4)), 1, $urandom);
        end
      endcase
    end

    // R11 full export compare
    for (int e = 0; e < N; e++) begin
      check(cfgTable[e*32 +: 32] == cfgM[e], "R11 cfg table", cfgTable[e*32 +: 32], cfgM[e]);
      check(dstTable[e*8 +: 8] == dstM[e], "R11 dst table", {24'b0, dstTable[e*8 +: 8]}, {24'b0, dstM[e]});
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule